// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer

This block keeps a 32-bit bus time made of three fields packed into one word. The offset field occupies bits 11:0 and counts reference ticks from 0 to 3071. The cycle field occupies bits 24:12 and counts 125 µs cycles from 0 to 7999. The seconds field occupies bits 31:25 and counts from 0 to 127. A single-cycle `tick_i` strobe marks each period of the 24.576 MHz reference. The counter is a mixed-radix chain: an offset wrap advances the cycle field, and a cycle wrap advances seconds.

The node acts as cycle master when `master_en_i` and `root_i` are both high. In that role it raises a one-cycle cycle-start request each time the timer rolls into a new cycle. It also watches how long the bus takes from the start of each cycle-start transmission to the end of the following subaction gap. In every other case the node is a slave. Each received cycle-start then reloads the whole word, and the block flags a cycle-start that fails to arrive while the local count carries on.

The host may overwrite the whole word at any time. A host write beats both a received reload and a tick in the same clock cycle.

Top module: `iso_cycle_timer`

## Requirements
- R1: While `rst_ni` is low, `time_o` is 0 and `cs_req_o`, `too_long_o` and `cycle_lost_o` are low.
- R2: With `timer_en_i` high, every clock cycle with `tick_i` high adds one to the offset field (bits 11:0). An offset of 3071 wraps to 0 and adds one to the cycle field (bits 24:12).
- R3: When the cycle field wraps from 7999 to 0, the seconds field (bits 31:25) gains one. Seconds wrap from 127 to 0.
- R4: While `timer_en_i` is low, ticks have no effect and `time_o` holds its value.
- R5: `host_wr_i` loads `host_wdata_i` into all three fields at the next edge. The write overrides a tick and a received cycle-start in the same cycle.
- R6: When the node is not cycle master, `rx_cs_valid_i` loads `rx_cs_data_i` into the whole word, even while `timer_en_i` is low. When the node is cycle master, received cycle-starts are ignored.
- R7: When `master_en_i` and `root_i` are both high, `cs_req_o` pulses for exactly one clock cycle. The pulse appears in the cycle where `time_o` first shows the new cycle with offset 0. No pulse occurs when either input is low.
- R8: As cycle master, `too_long_o` pulses once if more than 3072 ticks pass after `cs_tx_start_i` without `subgap_end_i`. Exactly 3072 ticks followed by `subgap_end_i` gives no pulse.
- R9: As slave, once a cycle-start has been received, a local rollover into a new cycle pulses `cycle_lost_o` if no cycle-start arrived since the previous rollover. The count keeps advancing on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One pulse per 24.576 MHz reference period |
| timer_en_i | input | 1 | Allows ticks to advance the count |
| master_en_i | input | 1 | Cycle-master enable |
| root_i | input | 1 | Node has been reported as bus root |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 32 | Host write value |
| rx_cs_valid_i | input | 1 | A cycle-start packet was received |
| rx_cs_data_i | input | 32 | Time carried by the received cycle-start |
| cs_tx_start_i | input | 1 | Transmission of a cycle-start has begun |
| subgap_end_i | input | 1 | End of the subaction gap after the cycle-start |
| time_o | output | 32 | Current bus time {seconds, cycle, offset} |
| cs_req_o | output | 1 | Cycle-start request pulse |
| too_long_o | output | 1 | Cycle-too-long event pulse |
| cycle_lost_o | output | 1 | Missing cycle-start event pulse |

## Verification
The counting chain is driven from chosen preload points with tick runs of set lengths. Short runs show a plain offset step. Runs across 3071 isolate the carry into the cycle field. Runs across cycle 7999 isolate the carry into seconds, and a run from 127/7999/3071 checks the double wrap back to zero. Priority is checked by colliding a host write with a tick and with a received cycle-start in the same cycle. The two event monitors are probed on both sides of their limits: 3072 against 3073 ticks for the long cycle, and one cycle with a cycle-start against one cycle without for the lost start.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int N_FIELDS = 3;
  localparam int TIME_W   = 32;
  // field order: offset, cycle, seconds (carry runs upward)
  localparam int FIELD_W   [N_FIELDS] = '{12, 13, 7};
  localparam int FIELD_LSB [N_FIELDS] = '{0, 12, 25};
endpackage

// File: rtl/ct_wrap_cnt.sv
module ct_wrap_cnt #(
  parameter int W   = 12,
  parameter int MOD = 3072
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (ld_i)  q <= ld_val_i;
    else if (inc_i) q <= (q >= LAST) ? '0 : q + W'(1);
  end

  assign q_o = q;

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && inc_i && q < LAST) |=> q == $past(q) + W'(1));
  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && inc_i && q == LAST) |=> q == '0);
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !inc_i) |=> $stable(q));
  // R5
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q == $past(ld_val_i));
endmodule

// File: rtl/ct_long_mon.sv
module ct_long_mon #(
  parameter int LIMIT = 3072
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic end_i,
  output logic too_long_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          too_long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      too_long_q <= 1'b0;
    end else begin
      too_long_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (end_i) begin
        active_q <= 1'b0;
      end else if (active_q && tick_i) begin
        if (cnt_q == LIM) begin
          too_long_q <= 1'b1;
          active_q   <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign too_long_o = too_long_q;

  // R8
  too_long_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    too_long_q |-> $past(active_q) && !active_q);
  // R8
  too_long_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    too_long_q |=> !too_long_q);
endmodule

// File: rtl/ct_lost_mon.sv
module ct_lost_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic rx_i,
  input  logic roll_i,
  output logic lost_o
);
  logic armed_q, seen_q, lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      lost_q <= 1'b0;
      if (master_i) begin
        armed_q <= 1'b0;
        seen_q  <= 1'b0;
      end else if (rx_i) begin
        armed_q <= 1'b1;
        seen_q  <= 1'b1;
      end else if (roll_i) begin
        lost_q <= armed_q && !seen_q;
        seen_q <= 1'b0;
      end
    end
  end

  assign lost_o = lost_q;

  // R9
  lost_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |-> !$past(master_i) && $past(roll_i));
  // R9
  lost_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |=> !lost_q);
endmodule

// File: rtl/iso_cycle_timer.sv
module iso_cycle_timer
  import ct_pkg::*;
#(
  parameter int FIELD_MOD [N_FIELDS] = '{3072, 8000, 128}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              timer_en_i,
  input  logic              master_en_i,
  input  logic              root_i,
  input  logic              host_wr_i,
  input  logic [TIME_W-1:0] host_wdata_i,
  input  logic              rx_cs_valid_i,
  input  logic [TIME_W-1:0] rx_cs_data_i,
  input  logic              cs_tx_start_i,
  input  logic              subgap_end_i,
  output logic [TIME_W-1:0] time_o,
  output logic              cs_req_o,
  output logic              too_long_o,
  output logic              cycle_lost_o
);
  localparam int OFF_W = FIELD_W[0];

  logic                acting;
  logic                ld;
  logic [TIME_W-1:0]   ld_val;
  logic [N_FIELDS-1:0] inc;
  logic                roll;
  logic                cs_req_q;

  assign acting = master_en_i & root_i;
  // host write wins over a received reload
  assign ld     = host_wr_i | (rx_cs_valid_i & ~acting);
  assign ld_val = host_wr_i ? host_wdata_i : rx_cs_data_i;
  assign inc[0] = tick_i & timer_en_i & ~ld;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    localparam int W   = FIELD_W[i];
    localparam int LSB = FIELD_LSB[i];
    logic [W-1:0] q;

    ct_wrap_cnt #(.W(W), .MOD(FIELD_MOD[i])) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (inc[i]),
      .ld_i     (ld),
      .ld_val_i (ld_val[LSB +: W]),
      .q_o      (q)
    );
    assign time_o[LSB +: W] = q;

    if (i < N_FIELDS - 1) begin : g_carry
      assign inc[i+1] = inc[i] & (q >= W'(FIELD_MOD[i] - 1));
    end
  end

  assign roll = inc[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_req_q <= 1'b0;
    else         cs_req_q <= acting & roll;
  end
  assign cs_req_o = cs_req_q;

  ct_long_mon #(.LIMIT(FIELD_MOD[0])) u_long (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .start_i    (cs_tx_start_i & acting),
    .end_i      (subgap_end_i),
    .too_long_o (too_long_o)
  );

  ct_lost_mon u_lost (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (acting),
    .rx_i     (rx_cs_valid_i),
    .roll_i   (roll),
    .lost_o   (cycle_lost_o)
  );

  // R7
  cs_req_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_req_q |-> time_o[OFF_W-1:0] == '0 && $past(acting));
  // R7
  cs_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_req_q |=> !cs_req_q);
  // R6
  master_ignore_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acting && !host_wr_i && !inc[0]) |=> $stable(time_o));
endmodule

// File: tb/iso_cycle_timer_tb.sv
module iso_cycle_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  function automatic logic [31:0] mk(int s, int c, int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  // table: start value, tick count, expected value
  localparam logic [31:0] V_START [NV] = '{
    {7'd0, 13'd0, 12'd0}, {7'd0, 13'd0, 12'd3070}, {7'd0, 13'd7999, 12'd3071},
    {7'd127, 13'd7999, 12'd3071}, {7'd5, 13'd100, 12'd3000}, {7'd3, 13'd7998, 12'd3071}};
  localparam int V_N [NV] = '{5, 3, 1, 2, 100, 3073};
  localparam logic [31:0] V_EXP [NV] = '{
    {7'd0, 13'd0, 12'd5}, {7'd0, 13'd1, 12'd1}, {7'd1, 13'd0, 12'd0},
    {7'd0, 13'd0, 12'd1}, {7'd5, 13'd101, 12'd28}, {7'd4, 13'd0, 12'd0}};

  logic clk = 0, rst_ni = 0;
  logic tick = 0, timer_en = 0, master_en = 0, root = 0;
  logic host_wr = 0, rx_valid = 0, tx_start = 0, gap_end = 0;
  logic [31:0] wdata = '0, rx_data = '0;
  logic [31:0] time_w;
  logic cs_req, too_long, lost;

  int tests = 0, fails = 0;
  int tl_cnt = 0, lost_cnt = 0;
  int snap;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_cycle_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .timer_en_i(timer_en),
    .master_en_i(master_en), .root_i(root), .host_wr_i(host_wr),
    .host_wdata_i(wdata), .rx_cs_valid_i(rx_valid), .rx_cs_data_i(rx_data),
    .cs_tx_start_i(tx_start), .subgap_end_i(gap_end), .time_o(time_w),
    .cs_req_o(cs_req), .too_long_o(too_long), .cycle_lost_o(lost));

  always @(negedge clk) begin
    if (too_long) tl_cnt++;
    if (lost) lost_cnt++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [31:0] v, logic tk);
    @(negedge clk); host_wr = 1; wdata = v; tick = tk;
    @(negedge clk); host_wr = 0; tick = 0;
  endtask

  task automatic run_ticks(int n);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 time", time_w, 32'd0);
    check("R1 outputs", {29'd0, cs_req, too_long, lost}, 32'd0);
    rst_ni = 1;
    timer_en = 1;

    // R2 / R3 table walk
    for (int i = 0; i < NV; i++) begin
      do_write(V_START[i], 0);
      run_ticks(V_N[i]);
      check((i < 2) ? "R2 count" : "R3 wrap", time_w, V_EXP[i]);
    end

    // R4 disabled timer holds
    timer_en = 0;
    do_write(mk(0, 0, 10), 0);
    run_ticks(5);
    check("R4 hold", time_w, mk(0, 0, 10));

    // R5 write beats tick, write beats rx reload
    timer_en = 1;
    do_write(mk(9, 42, 77), 1);
    check("R5 write over tick", time_w, mk(9, 42, 77));
    @(negedge clk); host_wr = 1; wdata = mk(1, 2, 3); rx_valid = 1; rx_data = mk(4, 5, 6);
    @(negedge clk); host_wr = 0; rx_valid = 0;
    check("R5 write over rx", time_w, mk(1, 2, 3));

    // R6 slave reload with timer disabled, master ignores rx
    timer_en = 0;
    @(negedge clk); rx_valid = 1; rx_data = mk(17, 1234, 2047);
    @(negedge clk); rx_valid = 0;
    check("R6 slave reload", time_w, mk(17, 1234, 2047));
    master_en = 1; root = 1;
    @(negedge clk); rx_valid = 1; rx_data = mk(99, 99, 99);
    @(negedge clk); rx_valid = 0;
    check("R6 master ignores rx", time_w, mk(17, 1234, 2047));

    // R7 cycle-start request
    timer_en = 1;
    do_write(mk(0, 5, 3071), 0);
    run_ticks(1);
    check("R7 req pulse", {31'd0, cs_req}, 32'd1);
    check("R7 new cycle", time_w, mk(0, 6, 0));
    @(negedge clk);
    check("R7 single cycle", {31'd0, cs_req}, 32'd0);
    root = 0;
    do_write(mk(0, 5, 3071), 0);
    run_ticks(1);
    check("R7 no req without root", {31'd0, cs_req}, 32'd0);
    check("R7 local advance", time_w, mk(0, 6, 0));

    // R8 cycle too long
    root = 1;
    do_write(mk(0, 0, 0), 0);
    snap = tl_cnt;
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0;
    run_ticks(3072);
    gap_end = 1;
    @(negedge clk); gap_end = 0;
    @(negedge clk);
    check("R8 at limit", 32'(tl_cnt - snap), 32'd0);
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0;
    run_ticks(3073);
    @(negedge clk);
    check("R8 over limit", 32'(tl_cnt - snap), 32'd1);
    gap_end = 1;
    @(negedge clk); gap_end = 0;

    // R9 lost cycle-start
    master_en = 0; root = 0;
    do_write(mk(0, 0, 3000), 0);
    snap = lost_cnt;
    @(negedge clk); rx_valid = 1; rx_data = mk(0, 0, 3000);
    @(negedge clk); rx_valid = 0;
    run_ticks(72);
    @(negedge clk);
    check("R9 start seen", 32'(lost_cnt - snap), 32'd0);
    check("R9 time", time_w, mk(0, 1, 0));
    run_ticks(3072);
    check("R9 local time kept", time_w, mk(0, 2, 0));
    @(negedge clk);
    check("R9 start missing", 32'(lost_cnt - snap), 32'd1);

    finish_run();
  end
endmodule